// File: doc/BRIEF.md
# DMA Channel Register File

This block is the host-side register file of a four-channel DMA controller. A byte-wide port space of sixteen locations reaches each channel's 16-bit base and current address and word count, the per-channel mode bytes, a command register, a status register, a request register, a temporary register and a four-bit channel mask. Because the data path is only eight bits wide, all 16-bit values go through a single byte pointer. The pointer is low after reset and flips on every access to an address or count port. Several write-only locations are commands rather than storage: pointer clear, master clear, mask clear, single mask bit and full mask load.

A transfer engine sits beside the block. It reads the current address, count, mode, mask and controller-disable bit on flat output buses. After a transfer it returns the new address and count for one channel through an update strobe. A terminal-count flag on that strobe records the channel's terminal count in the status register and clears its request bit. It then either reloads the channel from its base copies (auto-initialise) or masks the channel.

The only state machine is the byte pointer, with two states, `PTR_LO` and `PTR_HI`. Its transitions are: `PTR_LO` to `PTR_HI` on a word-port access; `PTR_HI` to `PTR_LO` on a word-port access; and either state to `PTR_LO` on a pointer-clear or master-clear write. A clear wins over a step in the same cycle.

Top module: `dmac_reg_block`

## Requirements
- R1: The byte pointer is 0 after reset. Every read or write of a word port flips it: address ports are 0-3 for channels 0-3, and count ports are 4-7. Pointer 0 reaches bits 7:0 and pointer 1 reaches bits 15:8.
- R2: A write to a word port stores the byte in both the base and the current copy. A read of a word port returns the byte of the current copy. The current copies appear on `eng_addr` and `eng_count`, 16 bits per channel with channel n at bits n*16.
- R3: A read of port 8 returns the status byte, with request bits in 7:4 and terminal-count bits in 3:0. It then clears the terminal-count bits and leaves the request bits.
- R4: A write to port 10 selects a channel with data bits 1:0. Data bit 2 set masks that channel, and data bit 2 clear unmasks it. No other mask bit changes.
- R5: A write to port 11 selects a channel with data bits 1:0 and stores the whole byte as that channel's mode, shown on `eng_mode` (8 bits per channel). Mode layout: bits 3:2 transfer type (00 verify, 01 write, 10 read), bit 4 auto-initialise, bit 5 address decrement, bits 7:6 mode.
- R6: A write to port 12 forces the byte pointer to 0, whatever the data.
- R7: A write to port 13 (master clear) zeroes the command, status, request and temporary registers and the pointer, and sets all mask bits. Mode, address and count registers keep their values.
- R8: A write to port 14 unmasks all channels. A write to port 15 loads the mask from data bits 3:0.
- R9: After reset the mask is 0xF and the command and status are 0. Channel 0 (the cascade channel) has mode 0xC0 (mode field 11). The other channels have mode 0x40 (mode field 01).
- R10: Reads of write-only or unused ports (9, 10, 11, 12, 14, 15) return 0x00 and change no state. `bus_rdata` is 0x00 whenever no read is selected. Port 13 reads the temporary register.
- R11: When `upd_valid` is high, `upd_addr` and `upd_count` become the current address and count of channel `upd_chan`. When `upd_tc` is also high, the block sets that channel's terminal-count bit and clears its request bit. If mode bit 4 is set, it then reloads current address and count from the base copies; otherwise it sets the channel's mask bit.
- R12: A terminal count in the same cycle as a status read leaves its bit set after the read, and the read returns the old byte. A terminal count in the same cycle as a host mask write leaves the channel masked.
- R13: A write to port 8 stores the command byte, and command bit 2 drives `eng_disable`. A write to port 9 selects a channel with data bits 1:0 and sets its request bit (data bit 2 = 1) or clears it (data bit 2 = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register space selected |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_rd | input | 1 | Read strobe, side effects at the clock edge |
| bus_addr | input | 4 | Port number |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while a read is selected |
| upd_valid | input | 1 | Engine update strobe |
| upd_chan | input | 2 | Channel being updated |
| upd_addr | input | 16 | New current address |
| upd_count | input | 16 | New current count |
| upd_tc | input | 1 | Terminal count reached by this update |
| eng_addr | output | 64 | Current addresses, channel n at n*16 |
| eng_count | output | 64 | Current counts, channel n at n*16 |
| eng_mode | output | 32 | Mode bytes, channel n at n*8 |
| eng_mask | output | 4 | Channel mask bits |
| eng_disable | output | 1 | Controller-disable (command bit 2) |

## Verification
Two events can land in the same cycle: the engine's terminal-count update and a host access that clears the same state. The host access is either a status read that clears terminal-count bits or a mask write that unmasks the channel. The bench drives the status read and the terminal-count update together. It expects the read to return the old byte, and a second read to show the new terminal-count bit. It then drives an unmask of the channel together with its terminal count and expects the mask bit to end up set.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int PORT_W = 4;

    typedef enum logic {PTR_LO = 1'b0, PTR_HI = 1'b1} ptr_state_t;

    localparam logic [PORT_W-1:0] P_CMD_STAT  = 4'h8;
    localparam logic [PORT_W-1:0] P_REQ       = 4'h9;
    localparam logic [PORT_W-1:0] P_SMASK     = 4'hA;
    localparam logic [PORT_W-1:0] P_MODE      = 4'hB;
    localparam logic [PORT_W-1:0] P_CLRPTR    = 4'hC;
    localparam logic [PORT_W-1:0] P_MCLR_TEMP = 4'hD;
    localparam logic [PORT_W-1:0] P_CLRMASK   = 4'hE;
    localparam logic [PORT_W-1:0] P_ALLMASK   = 4'hF;

    localparam logic [1:0] MODE_SINGLE  = 2'b01;
    localparam logic [1:0] MODE_CASCADE = 2'b11;
    localparam int MODE_AUTOINIT_BIT = 4;
    localparam int CMD_DISABLE_BIT   = 2;

    function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                   input logic hi,
                                                   input logic [BYTE_W-1:0] b);
        logic [WORD_W-1:0] r;
        r = w;
        if (hi) r[15:8] = b;
        else    r[7:0]  = b;
        return r;
    endfunction
endpackage

// File: rtl/dmac_ptr_fsm.sv
module dmac_ptr_fsm
    import dmac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    output logic ptr_hi
);
    ptr_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_LO: begin
                if (clear)     state_d = PTR_LO;
                else if (step) state_d = PTR_HI;
            end
            PTR_HI: begin
                if (clear || step) state_d = PTR_LO;
            end
            default: state_d = PTR_LO;
        endcase
    end

    always_comb begin
        ptr_hi = (state_q == PTR_HI);
    end
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RST_MODE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              wr_mode,
    input  logic              upd_en,
    input  logic [WORD_W-1:0] upd_addr,
    input  logic [WORD_W-1:0] upd_cnt,
    input  logic              reload,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_cnt,
    output logic [BYTE_W-1:0] mode
);
    logic [WORD_W-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
    logic [BYTE_W-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr_q <= '0;
            base_cnt_q  <= '0;
            cur_addr_q  <= '0;
            cur_cnt_q   <= '0;
            mode_q      <= RST_MODE;
        end else begin
            if (wr_addr) begin
                base_addr_q <= put_byte(base_addr_q, hi, wdata);
                cur_addr_q  <= put_byte(cur_addr_q, hi, wdata);
            end else if (reload) begin
                cur_addr_q  <= base_addr_q;
            end else if (upd_en) begin
                cur_addr_q  <= upd_addr;
            end
            if (wr_cnt) begin
                base_cnt_q <= put_byte(base_cnt_q, hi, wdata);
                cur_cnt_q  <= put_byte(cur_cnt_q, hi, wdata);
            end else if (reload) begin
                cur_cnt_q  <= base_cnt_q;
            end else if (upd_en) begin
                cur_cnt_q  <= upd_cnt;
            end
            if (wr_mode) mode_q <= wdata;
        end
    end

    always_comb begin
        cur_addr = cur_addr_q;
        cur_cnt  = cur_cnt_q;
        mode     = mode_q;
    end
endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
    import dmac_pkg::*;
#(
    parameter int NCH  = 4,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mclr,
    input  logic              wr_cmd,
    input  logic              wr_req,
    input  logic              wr_smask,
    input  logic              clr_mask,
    input  logic              wr_allmask,
    input  logic              rd_status,
    input  logic              tc_en,
    input  logic [CH_W-1:0]   tc_chan,
    input  logic              tc_autoinit,
    output logic [BYTE_W-1:0] cmd,
    output logic [NCH-1:0]    req,
    output logic [NCH-1:0]    tc,
    output logic [NCH-1:0]    mask,
    output logic [BYTE_W-1:0] temp
);
    logic [BYTE_W-1:0] cmd_q, temp_q;
    logic [NCH-1:0]    req_q, tc_q, mask_q;
    logic [NCH-1:0]    req_d, tc_d, mask_d;
    logic [NCH-1:0]    sel_onehot, tc_onehot;

    always_comb begin
        sel_onehot = '0;
        sel_onehot[wdata[CH_W-1:0]] = 1'b1;
        tc_onehot = '0;
        tc_onehot[tc_chan] = 1'b1;

        // host side first
        mask_d = mask_q;
        if (mclr)            mask_d = '1;
        else if (clr_mask)   mask_d = '0;
        else if (wr_allmask) mask_d = wdata[NCH-1:0];
        else if (wr_smask)   mask_d = wdata[2] ? (mask_q | sel_onehot) : (mask_q & ~sel_onehot);

        req_d = req_q;
        if (mclr)        req_d = '0;
        else if (wr_req) req_d = wdata[2] ? (req_q | sel_onehot) : (req_q & ~sel_onehot);

        tc_d = tc_q;
        if (mclr || rd_status) tc_d = '0;

        // engine side last, so it wins
        if (tc_en) begin
            tc_d  = tc_d | tc_onehot;
            req_d = req_d & ~tc_onehot;
            if (!tc_autoinit) mask_d = mask_d | tc_onehot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            temp_q <= '0;
            req_q  <= '0;
            tc_q   <= '0;
            mask_q <= '1;
        end else begin
            if (mclr)        cmd_q <= '0;
            else if (wr_cmd) cmd_q <= wdata;
            if (mclr)        temp_q <= '0;
            req_q  <= req_d;
            tc_q   <= tc_d;
            mask_q <= mask_d;
        end
    end

    always_comb begin
        cmd  = cmd_q;
        req  = req_q;
        tc   = tc_q;
        mask = mask_q;
        temp = temp_q;
    end
endmodule

// File: rtl/dmac_reg_block.sv
module dmac_reg_block
    import dmac_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int CASCADE_CH  = 0,
    parameter bit HAS_CASCADE = 1'b1,
    localparam int CH_W       = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [PORT_W-1:0]     bus_addr,
    input  logic [BYTE_W-1:0]     bus_wdata,
    output logic [BYTE_W-1:0]     bus_rdata,
    input  logic                  upd_valid,
    input  logic [CH_W-1:0]       upd_chan,
    input  logic [WORD_W-1:0]     upd_addr,
    input  logic [WORD_W-1:0]     upd_count,
    input  logic                  upd_tc,
    output logic [NCH*WORD_W-1:0] eng_addr,
    output logic [NCH*WORD_W-1:0] eng_count,
    output logic [NCH*BYTE_W-1:0] eng_mode,
    output logic [NCH-1:0]        eng_mask,
    output logic                  eng_disable
);
    logic wr_en, rd_en, word_port, ptr_hi, autoinit_sel;
    logic mclr, tc_en;
    logic [WORD_W-1:0] addr_a [NCH];
    logic [WORD_W-1:0] cnt_a  [NCH];
    logic [BYTE_W-1:0] mode_a [NCH];
    logic [BYTE_W-1:0] cmd_q, temp_q;
    logic [NCH-1:0]    req_bits, tc_bits, mask_bits;
    logic [WORD_W-1:0] rd_word;

    always_comb begin
        wr_en     = bus_sel & bus_wr;
        rd_en     = bus_sel & bus_rd & ~bus_wr;
        word_port = ~bus_addr[3];
        mclr      = wr_en & (bus_addr == P_MCLR_TEMP);
        tc_en     = upd_valid & upd_tc;
        autoinit_sel = mode_a[upd_chan][MODE_AUTOINIT_BIT];
    end

    dmac_ptr_fsm u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  ((wr_en | rd_en) & word_port),
        .clear (mclr | (wr_en & (bus_addr == P_CLRPTR))),
        .ptr_hi(ptr_hi)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [BYTE_W-1:0] RM =
            (HAS_CASCADE && (c == CASCADE_CH)) ? {MODE_CASCADE, 6'b0} : {MODE_SINGLE, 6'b0};
        logic hit;
        logic upd_hit;
        always_comb begin
            hit     = wr_en & word_port & (bus_addr[CH_W-1:0] == CH_W'(c));
            upd_hit = upd_valid & (upd_chan == CH_W'(c));
        end
        dmac_chan_regs #(.RST_MODE(RM)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .hi      (ptr_hi),
            .wdata   (bus_wdata),
            .wr_addr (hit & ~bus_addr[2]),
            .wr_cnt  (hit & bus_addr[2]),
            .wr_mode (wr_en & (bus_addr == P_MODE) & (bus_wdata[CH_W-1:0] == CH_W'(c))),
            .upd_en  (upd_hit),
            .upd_addr(upd_addr),
            .upd_cnt (upd_count),
            .reload  (upd_hit & upd_tc & mode_a[c][MODE_AUTOINIT_BIT]),
            .cur_addr(addr_a[c]),
            .cur_cnt (cnt_a[c]),
            .mode    (mode_a[c])
        );
        always_comb begin
            eng_addr[c*WORD_W +: WORD_W]  = addr_a[c];
            eng_count[c*WORD_W +: WORD_W] = cnt_a[c];
            eng_mode[c*BYTE_W +: BYTE_W]  = mode_a[c];
        end
    end

    dmac_ctrl_regs #(.NCH(NCH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdata      (bus_wdata),
        .mclr       (mclr),
        .wr_cmd     (wr_en & (bus_addr == P_CMD_STAT)),
        .wr_req     (wr_en & (bus_addr == P_REQ)),
        .wr_smask   (wr_en & (bus_addr == P_SMASK)),
        .clr_mask   (wr_en & (bus_addr == P_CLRMASK)),
        .wr_allmask (wr_en & (bus_addr == P_ALLMASK)),
        .rd_status  (rd_en & (bus_addr == P_CMD_STAT)),
        .tc_en      (tc_en),
        .tc_chan    (upd_chan),
        .tc_autoinit(autoinit_sel),
        .cmd        (cmd_q),
        .req        (req_bits),
        .tc         (tc_bits),
        .mask       (mask_bits),
        .temp       (temp_q)
    );

    always_comb begin
        eng_mask    = mask_bits;
        eng_disable = cmd_q[CMD_DISABLE_BIT];
        rd_word     = bus_addr[2] ? cnt_a[bus_addr[CH_W-1:0]] : addr_a[bus_addr[CH_W-1:0]];
        bus_rdata   = '0;
        if (rd_en) begin
            if (word_port)                      bus_rdata = ptr_hi ? rd_word[15:8] : rd_word[7:0];
            else if (bus_addr == P_CMD_STAT)    bus_rdata = {req_bits, tc_bits};
            else if (bus_addr == P_MCLR_TEMP)   bus_rdata = temp_q;
        end
    end
endmodule

// File: rtl/dmac_reg_block_chk.sv
module dmac_reg_block_chk #(
    parameter int NCH = 4,
    localparam int CH_W = $clog2(NCH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_en,
    input logic            wr_en,
    input logic [3:0]      bus_addr,
    input logic [7:0]      bus_wdata,
    input logic [7:0]      bus_rdata,
    input logic            ptr_hi,
    input logic [NCH-1:0]  tc_bits,
    input logic [NCH-1:0]  eng_mask,
    input logic            eng_disable,
    input logic            upd_valid,
    input logic            upd_tc,
    input logic [CH_W-1:0] upd_chan,
    input logic            autoinit_sel
);
    AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !bus_addr[3]) |=> (ptr_hi != $past(ptr_hi))); // R1
    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == 4'hC) |=> !ptr_hi); // R6
    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == 4'h8 && !(upd_valid && upd_tc)) |=> (tc_bits == '0)); // R3
    AST_MASTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == 4'hD) |=> (eng_mask == '1 && !eng_disable && !ptr_hi)); // R7
    AST_SINGLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == 4'hA && !(upd_valid && upd_tc))
        |=> (eng_mask[$past(bus_wdata[CH_W-1:0])] == $past(bus_wdata[2]))); // R4
    AST_TC_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_tc && !autoinit_sel) |=> eng_mask[$past(upd_chan)]); // R11
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (bus_rdata == 8'h00)); // R10
endmodule

bind dmac_reg_block dmac_reg_block_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ptr_hi      (ptr_hi),
    .tc_bits     (tc_bits),
    .eng_mask    (eng_mask),
    .eng_disable (eng_disable),
    .upd_valid   (upd_valid),
    .upd_tc      (upd_tc),
    .upd_chan    (upd_chan),
    .autoinit_sel(autoinit_sel)
);

// File: tb/dmac_reg_block_tb.sv
module dmac_reg_block_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        upd_valid = 0, upd_tc = 0;
    logic [1:0]  upd_chan = '0;
    logic [15:0] upd_addr = '0, upd_count = '0;
    logic [63:0] eng_addr, eng_count;
    logic [31:0] eng_mode;
    logic [3:0]  eng_mask;
    logic        eng_disable;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_reg_block u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd_valid(upd_valid), .upd_chan(upd_chan), .upd_addr(upd_addr),
        .upd_count(upd_count), .upd_tc(upd_tc), .eng_addr(eng_addr),
        .eng_count(eng_count), .eng_mode(eng_mode), .eng_mask(eng_mask),
        .eng_disable(eng_disable)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        bus_sel = 0; bus_wr = 0; bus_rd = 0; upd_valid = 0; upd_tc = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic drive_upd(input logic [1:0] ch, input logic [15:0] a,
                             input logic [15:0] c, input logic tc);
        upd_valid = 1; upd_chan = ch; upd_addr = a; upd_count = c; upd_tc = tc;
    endtask

    task automatic upd(input logic [1:0] ch, input logic [15:0] a,
                       input logic [15:0] c, input logic tc);
        @(negedge clk);
        drive_upd(ch, a, c, tc);
        @(negedge clk);
        idle_bus();
    endtask

    task automatic t_reset();
        check("R9 mask", eng_mask, 4'hF);
        check("R9 mode ch0 cascade", eng_mode[7:0], 8'hC0);
        check("R9 mode ch1 single", eng_mode[15:8], 8'h40);
        check("R9 disable", eng_disable, 1'b0);
        rd(4'h8, rv); check("R9 status", rv, 8'h00);
        check("R10 idle rdata", bus_rdata, 8'h00);
    endtask

    task automatic t_word_access();
        wr(4'h1, 8'h34); wr(4'h1, 8'h12);
        check("R1 R2 addr ch1", eng_addr[31:16], 16'h1234);
        rd(4'h1, rv); check("R1 read low", rv, 8'h34);
        rd(4'h1, rv); check("R1 read high", rv, 8'h12);
        wr(4'h6, 8'h05); wr(4'h6, 8'h00);
        check("R2 count ch2", eng_count[47:32], 16'h0005);
    endtask

    task automatic t_clear_ptr();
        wr(4'h1, 8'h77);
        wr(4'hC, 8'hFF);
        wr(4'h1, 8'h56);
        check("R6 low byte after clear", eng_addr[31:16], 16'h1256);
        wr(4'hC, 8'h00);
    endtask

    task automatic t_mask();
        wr(4'hE, 8'hFF); check("R8 clear mask", eng_mask, 4'h0);
        wr(4'hA, 8'h06); check("R4 set ch2", eng_mask, 4'h4);
        wr(4'hA, 8'h07); check("R4 set ch3", eng_mask, 4'hC);
        wr(4'hA, 8'h02); check("R4 clear ch2", eng_mask, 4'h8);
        wr(4'hF, 8'h5A); check("R8 write all", eng_mask, 4'hA);
    endtask

    task automatic t_mode();
        wr(4'hB, 8'h5B);
        check("R5 mode ch3", eng_mode[31:24], 8'h5B);
        check("R5 ch2 untouched", eng_mode[23:16], 8'h40);
    endtask

    task automatic t_cmd_req();
        wr(4'h8, 8'h04); check("R13 disable", eng_disable, 1'b1);
        wr(4'h9, 8'h05);
        rd(4'h8, rv); check("R13 R3 request in status", rv, 8'h20);
        wr(4'h9, 8'h01);
        rd(4'h8, rv); check("R13 request cleared", rv, 8'h00);
        wr(4'h9, 8'h05);
    endtask

    task automatic t_unused_reads();
        rd(4'hE, rv); check("R10 port14", rv, 8'h00);
        rd(4'hB, rv); check("R10 port11", rv, 8'h00);
        rd(4'hF, rv); check("R10 port15", rv, 8'h00);
        rd(4'hA, rv); check("R10 port10", rv, 8'h00);
        rd(4'h9, rv); check("R10 port9", rv, 8'h00);
        rd(4'hC, rv); check("R10 port12", rv, 8'h00);
        check("R10 mask kept", eng_mask, 4'hA);
        rd(4'h1, rv); check("R10 pointer kept", rv, 8'h56);
    endtask

    task automatic t_master_clear();
        wr(4'hD, 8'h00);
        check("R7 mask set", eng_mask, 4'hF);
        check("R7 command zero", eng_disable, 1'b0);
        check("R7 mode kept", eng_mode[31:24], 8'h5B);
        check("R7 addr kept", eng_addr[31:16], 16'h1256);
        rd(4'h8, rv); check("R7 status and request zero", rv, 8'h00);
        rd(4'hD, rv); check("R7 temp zero", rv, 8'h00);
        rd(4'h1, rv); check("R7 pointer zero", rv, 8'h56);
        wr(4'hC, 8'h00);
    endtask

    task automatic t_tc_mask();
        wr(4'hB, 8'h46);
        wr(4'hA, 8'h02);
        check("R4 unmask ch2", eng_mask, 4'hB);
        upd(2'd2, 16'h1000, 16'hFFFF, 1'b1);
        check("R11 addr update", eng_addr[47:32], 16'h1000);
        check("R11 count update", eng_count[47:32], 16'hFFFF);
        check("R11 mask on tc", eng_mask, 4'hF);
        rd(4'h8, rv); check("R11 R3 tc bit", rv, 8'h04);
        rd(4'h8, rv); check("R3 tc cleared by read", rv, 8'h00);
        upd(2'd2, 16'h2222, 16'h0003, 1'b0);
        check("R11 plain update", eng_addr[47:32], 16'h2222);
        rd(4'h8, rv); check("R11 no tc without flag", rv, 8'h00);
    endtask

    task automatic t_autoinit();
        wr(4'h3, 8'hCD); wr(4'h3, 8'hAB);
        wr(4'h7, 8'h10); wr(4'h7, 8'h00);
        wr(4'hB, 8'h57);
        wr(4'hA, 8'h03);
        upd(2'd3, 16'hABDE, 16'hFFFF, 1'b1);
        check("R11 reload addr", eng_addr[63:48], 16'hABCD);
        check("R11 reload count", eng_count[63:48], 16'h0010);
        check("R11 autoinit keeps mask", eng_mask, 4'h7);
        rd(4'h8, rv); check("R11 autoinit tc", rv, 8'h08);
    endtask

    task automatic t_collisions();
        wr(4'hE, 8'h00);
        wr(4'hB, 8'h45);
        wr(4'h9, 8'h05);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = 4'h8;
        drive_upd(2'd1, 16'h0100, 16'hFFFF, 1'b1);
        #1 rv = bus_rdata;
        @(negedge clk);
        idle_bus();
        check("R12 read returns old", rv, 8'h20);
        rd(4'h8, rv); check("R12 tc survives read", rv, 8'h02);
        wr(4'hE, 8'h00);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 4'hA; bus_wdata = 8'h01;
        drive_upd(2'd1, 16'h0200, 16'hFFFF, 1'b1);
        @(negedge clk);
        idle_bus();
        check("R12 tc mask wins", eng_mask, 4'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_access();
        t_clear_ptr();
        t_mask();
        t_mode();
        t_cmd_req();
        t_unused_reads();
        t_master_clear();
        t_tc_mask();
        t_autoinit();
        t_collisions();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule